// File: doc/BRIEF.md
# Paged Board Control Register Window

This block is the board-side register file of a 32-location network adapter I/O window. The low 16 locations are served locally. They hold a fixed identification word, a page-select register whose upper bits return a constant signature, a bitmapped option register, and an 8-location window at offsets 8 to 15. The contents of that window depend on the selected page. The high 16 locations are passed straight through to the network controller's register space.

A host first identifies the board through the ID word and the signature in the page register. It then selects the station-address page to read and verify the address and its checksum, and the hardware page to learn the IRQ number and the shared memory base. Finally it writes the option register to release the controller and board from reset and to enable interrupts. The station address and the hardware parameters arrive as input ports.

Reads are combinational, writes are word writes, and the register state is updated on the rising clock edge. A read at local offset `a` returns byte `a` in bits 7:0 and byte `a+1` in bits 15:8. Above offset 15 the upper byte reads zero.

Top module: `paged_board_regs`

## Requirements
- R1: A read at offset 0x00 always returns 0x4850, and writes there have no effect.
- R2: A write to offset 0x02 stores bus_wdata[3:0] as the page code. A read of offset 0x02 returns {12'h530, page}. The page code is 0 after system reset.
- R3: With page 1 selected, offsets 8 to 13 read station_addr[47:40] down to station_addr[7:0], in that order. Offset 14 reads a checksum byte chosen so that the byte sum of these seven bytes is 0xFF modulo 256. Offset 15 reads zero.
- R4: With page 2 selected, offsets 9 and 10 read hw_membase[7:0] and hw_membase[15:8]. Offset 13 reads {4'h0, hw_irq}. Offsets 14 and 15 read a 16-bit wrap register, which is written by a word write to offset 14 while page 2 is selected. All other window bytes read zero.
- R5: With page 4 selected, offsets 8 and 9 read lan_cfg[7:0] and lan_cfg[15:8]. With page 6 selected, offsets 12 and 13 read id_cfg[7:0] and id_cfg[15:8]. All other window bytes read zero.
- R6: With page 0 selected, word writes to offsets 8 and 10 store two 16-bit transfer address registers, which read back at those offsets. While option bit 1 is 0, both registers are held at zero and writes to them are ignored.
- R7: A write to offset 0x04 stores only option bits 7:0 and bit 12. All other bits read zero. The option register is 0 after system reset, and opt_bits shows its value.
- R8: nic_rst_n equals option bit 0 and brd_rst_n equals option bit 1, so both resets are asserted after system reset. Each output changes on the clock edge that takes the option write.
- R9: irq_out is high exactly when option bit 2 is set and either nic_irq or option bit 3 is high.
- R10: An access at offsets 0x10 to 0x1F drives nic_addr with bus_addr[3:0], raises nic_sel_rd or nic_sel_wr with the strobe, passes bus_wdata to nic_wdata, and returns nic_rdata. Such an access changes no board register.
- R11: When the page code is not 0, 1, 2, 4 or 6, the window reads zero and writes to it are ignored. Writes at offsets 0x00, 0x06 and every odd local offset are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| bus_addr | input | 5 | Byte offset within the 32-location window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| nic_sel_rd | output | 1 | Read strobe to the network controller |
| nic_sel_wr | output | 1 | Write strobe to the network controller |
| nic_addr | output | 4 | Controller register offset |
| nic_wdata | output | 16 | Write data to the controller |
| nic_rdata | input | 16 | Read data from the controller |
| nic_irq | input | 1 | Controller interrupt request |
| station_addr | input | 48 | Station address, first byte in the top bits |
| hw_irq | input | 4 | IRQ number parameter |
| hw_membase | input | 16 | Shared memory base parameter |
| lan_cfg | input | 16 | Transceiver / LAN parameters |
| id_cfg | input | 16 | Software configuration ID word |
| nic_rst_n | output | 1 | Controller reset, active low |
| brd_rst_n | output | 1 | Board logic reset, active low |
| irq_out | output | 1 | Combined interrupt output |
| opt_bits | output | 16 | Current option register value |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle. They also assume that the parameter inputs and nic_rdata settle before the bus strobes are sampled. The stimulus changes every input on the falling clock edge and raises only one strobe per access. It holds a write for a single cycle and then idles one more cycle, so that the board-reset clearing of the transfer addresses is complete before the next read.

// File: rtl/paged_board_regs.sv
module paged_board_regs #(
  parameter logic [15:0] ID_WORD  = 16'h4850,
  parameter logic [11:0] PAGE_SIG = 12'h530,
  parameter logic [15:0] OPT_MASK = 16'h10FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        nic_sel_rd,
  output logic        nic_sel_wr,
  output logic [3:0]  nic_addr,
  output logic [15:0] nic_wdata,
  input  logic [15:0] nic_rdata,
  input  logic        nic_irq,
  input  logic [47:0] station_addr,
  input  logic [3:0]  hw_irq,
  input  logic [15:0] hw_membase,
  input  logic [15:0] lan_cfg,
  input  logic [15:0] id_cfg,
  output logic        nic_rst_n,
  output logic        brd_rst_n,
  output logic        irq_out,
  output logic [15:0] opt_bits
);
  localparam logic [3:0] PG_RUN = 4'd0;
  localparam logic [3:0] PG_MAC = 4'd1;
  localparam logic [3:0] PG_HW  = 4'd2;
  localparam logic [3:0] PG_LAN = 4'd4;
  localparam logic [3:0] PG_ID  = 4'd6;

  logic [3:0]  page;
  logic [15:0] opt, xfer_out, xfer_in, wrap;
  logic [7:0]  mac_sum, csum;
  logic [7:0]  bytes [0:16];
  logic [4:0]  lo;
  logic        brd_wr;

  assign brd_wr     = bus_wr & ~bus_addr[4];
  assign nic_sel_rd = bus_rd & bus_addr[4];
  assign nic_sel_wr = bus_wr & bus_addr[4];
  assign nic_addr   = bus_addr[3:0];
  assign nic_wdata  = bus_wdata;

  assign nic_rst_n = opt[0];
  assign brd_rst_n = opt[1];
  assign irq_out   = opt[2] & (nic_irq | opt[3]);
  assign opt_bits  = opt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page     <= PG_RUN;
      opt      <= '0;
      xfer_out <= '0;
      xfer_in  <= '0;
      wrap     <= '0;
    end else begin
      if (brd_wr && bus_addr[3:0] == 4'd2) page <= bus_wdata[3:0];
      if (brd_wr && bus_addr[3:0] == 4'd4) opt  <= bus_wdata & OPT_MASK;
      if (brd_wr && bus_addr[3:0] == 4'd14 && page == PG_HW) wrap <= bus_wdata;
      if (!opt[1]) begin
        xfer_out <= '0;
        xfer_in  <= '0;
      end else if (brd_wr && page == PG_RUN) begin
        if (bus_addr[3:0] == 4'd8)  xfer_out <= bus_wdata;
        if (bus_addr[3:0] == 4'd10) xfer_in  <= bus_wdata;
      end
    end
  end

  always_comb begin
    mac_sum = '0;
    for (int i = 0; i < 6; i++) mac_sum = mac_sum + station_addr[47-8*i -: 8];
  end
  assign csum = 8'hFF - mac_sum;

  always_comb begin
    for (int i = 0; i < 17; i++) bytes[i] = '0;
    bytes[0] = ID_WORD[7:0];
    bytes[1] = ID_WORD[15:8];
    bytes[2] = {PAGE_SIG[3:0], page};
    bytes[3] = PAGE_SIG[11:4];
    bytes[4] = opt[7:0];
    bytes[5] = opt[15:8];
    case (page)
      PG_RUN: begin
        bytes[8]  = xfer_out[7:0];
        bytes[9]  = xfer_out[15:8];
        bytes[10] = xfer_in[7:0];
        bytes[11] = xfer_in[15:8];
      end
      PG_MAC: begin
        for (int i = 0; i < 6; i++) bytes[8+i] = station_addr[47-8*i -: 8];
        bytes[14] = csum;
      end
      PG_HW: begin
        bytes[9]  = hw_membase[7:0];
        bytes[10] = hw_membase[15:8];
        bytes[13] = {4'h0, hw_irq};
        bytes[14] = wrap[7:0];
        bytes[15] = wrap[15:8];
      end
      PG_LAN: begin
        bytes[8] = lan_cfg[7:0];
        bytes[9] = lan_cfg[15:8];
      end
      PG_ID: begin
        bytes[12] = id_cfg[7:0];
        bytes[13] = id_cfg[15:8];
      end
      default: ;
    endcase
  end

  assign lo        = {1'b0, bus_addr[3:0]};
  assign bus_rdata = bus_addr[4] ? nic_rdata : {bytes[lo + 5'd1], bytes[lo]};

  assert_id_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 5'd0 |-> bus_rdata == 16'h4850);

  assert_page_sig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 5'd2 |-> bus_rdata[15:4] == 12'h530);

  assert_checksum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 5'd14 && bus_rdata[11:0] != 12'h000 && page == PG_MAC) |->
      8'(bus_rdata[7:0] + station_addr[7:0] + station_addr[15:8] + station_addr[23:16]
         + station_addr[31:24] + station_addr[39:32] + station_addr[47:40]) == 8'hFF);

  assert_opt_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_bits & ~16'h10FF) == 16'h0000);

  assert_reset_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_wr) && $past(bus_addr) == 5'd4) |->
      (nic_rst_n == $past(bus_wdata[0]) && brd_rst_n == $past(bus_wdata[1])));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> opt_bits[2]);

  assert_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4]) |=> $stable(opt_bits));

  assert_xfer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!brd_rst_n && $past(!brd_rst_n) && page == PG_RUN && bus_addr == 5'd8) |-> bus_rdata == 16'h0000);
endmodule

// File: tb/paged_board_regs_tb.sv
`timescale 1ns/1ps
module paged_board_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, nic_rdata = '0;
  logic        nic_irq = 1'b0;
  logic [47:0] station_addr = 48'h0;
  logic [3:0]  hw_irq = '0;
  logic [15:0] hw_membase = '0, lan_cfg = '0, id_cfg = '0;
  logic [15:0] bus_rdata, nic_wdata, opt_bits;
  logic        nic_sel_rd, nic_sel_wr, nic_rst_n, brd_rst_n, irq_out;
  logic [3:0]  nic_addr;

  int checks = 0, fails = 0, cycles = 0;
  logic [3:0]  m_page = '0;
  logic [15:0] m_opt = '0, m_out = '0, m_in = '0, m_wrap = '0;

  always #2.5 clk = ~clk;

  paged_board_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nic_sel_rd(nic_sel_rd),
    .nic_sel_wr(nic_sel_wr), .nic_addr(nic_addr), .nic_wdata(nic_wdata),
    .nic_rdata(nic_rdata), .nic_irq(nic_irq), .station_addr(station_addr),
    .hw_irq(hw_irq), .hw_membase(hw_membase), .lan_cfg(lan_cfg), .id_cfg(id_cfg),
    .nic_rst_n(nic_rst_n), .brd_rst_n(brd_rst_n), .irq_out(irq_out), .opt_bits(opt_bits));

  task automatic chk(input logic ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st_byte(input int i);
    return station_addr[47-8*i -: 8];
  endfunction

  function automatic logic [7:0] exp_byte(input int k);
    logic [7:0] s;
    case (k)
      0: return 8'h50;
      1: return 8'h48;
      2: return {4'h0, m_page};
      3: return 8'h53;
      4: return m_opt[7:0];
      5: return m_opt[15:8];
      default: ;
    endcase
    if (k < 8 || k > 15) return 8'h00;
    case (m_page)
      4'd0: case (k) 8: return m_out[7:0]; 9: return m_out[15:8];
                     10: return m_in[7:0]; 11: return m_in[15:8]; default: return 8'h00; endcase
      4'd1: begin
        if (k <= 13) return st_byte(k - 8);
        if (k == 14) begin
          s = 8'h00;
          for (int i = 0; i < 6; i++) s = s + st_byte(i);
          return 8'hFF - s;
        end
        return 8'h00;
      end
      4'd2: case (k) 9: return hw_membase[7:0]; 10: return hw_membase[15:8];
                     13: return {4'h0, hw_irq}; 14: return m_wrap[7:0];
                     15: return m_wrap[15:8]; default: return 8'h00; endcase
      4'd4: case (k) 8: return lan_cfg[7:0]; 9: return lan_cfg[15:8]; default: return 8'h00; endcase
      4'd6: case (k) 12: return id_cfg[7:0]; 13: return id_cfg[15:8]; default: return 8'h00; endcase
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input int a);
    if (a >= 16) return "R10";
    if (a == 0 || a == 1) return "R1";
    if (a == 2 || a == 3) return "R2";
    if (a == 4 || a == 5) return "R7";
    if (a < 8) return "R11";
    case (m_page)
      4'd0: return "R6";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd4, 4'd6: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] old_opt;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    if (a[4]) chk(nic_sel_wr && nic_addr == a[3:0] && nic_wdata == d, "R10 fwd write",
                  {nic_sel_wr, nic_addr, nic_wdata}, {1'b1, a[3:0], d});
    @(negedge clk);
    bus_wr = 1'b0;
    old_opt = m_opt;
    if (!a[4]) begin
      if (a[3:0] == 4'd2) m_page = d[3:0];
      if (a[3:0] == 4'd4) m_opt = d & 16'h10FF;
      if (a[3:0] == 4'd14 && m_page == 4'd2 && !(a[3:0] == 4'd2)) m_wrap = d;
      if (old_opt[1] && m_page == 4'd0 && a[3:0] == 4'd8) m_out = d;
      if (old_opt[1] && m_page == 4'd0 && a[3:0] == 4'd10) m_in = d;
    end
    if (!m_opt[1]) begin m_out = '0; m_in = '0; end
    @(negedge clk);
  endtask

  task automatic chk_outputs();
    #1;
    chk(nic_rst_n == m_opt[0] && brd_rst_n == m_opt[1], "R8 resets",
        {nic_rst_n, brd_rst_n}, {m_opt[0], m_opt[1]});
    chk(opt_bits == m_opt, "R7 opt_bits", opt_bits, m_opt);
    chk(irq_out == (m_opt[2] & (nic_irq | m_opt[3])), "R9 irq", irq_out,
        m_opt[2] & (nic_irq | m_opt[3]));
  endtask

  task automatic chk_read(input logic [4:0] a);
    logic [15:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; nic_rdata = 16'($urandom);
    #1;
    e = a[4] ? nic_rdata : {exp_byte(int'(a) + 1), exp_byte(int'(a))};
    chk(bus_rdata == e, req_of(int'(a)), bus_rdata, e);
    if (a[4]) chk(nic_sel_rd && nic_addr == a[3:0], "R10 fwd read",
                  {nic_sel_rd, nic_addr}, {1'b1, a[3:0]});
    bus_rd = 1'b0;
  endtask

  task automatic randomize_inputs();
    station_addr = {16'($urandom), 32'($urandom)};
    hw_irq = 4'($urandom); hw_membase = 16'($urandom);
    lan_cfg = 16'($urandom); id_cfg = 16'($urandom);
    nic_irq = 1'($urandom);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    randomize_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: page 0, option 0, resets asserted (R2, R7, R8)
    chk_outputs();
    chk(!nic_rst_n && !brd_rst_n, "R8 reset asserted", {nic_rst_n, brd_rst_n}, 2'b00);
    for (int a = 0; a < 16; a++) chk_read(5'(a));
    // R1: write to ID ignored
    do_write(5'd0, 16'hFFFF); chk_read(5'd0);
    // R6: transfer regs held while board reset
    do_write(5'd8, 16'hBEEF); chk_read(5'd8);
    do_write(5'd4, 16'hFFFF); chk_outputs();
    do_write(5'd8, 16'hBEEF); do_write(5'd10, 16'h1234);
    chk_read(5'd8); chk_read(5'd10); chk_read(5'd9);
    do_write(5'd4, 16'h0001); chk_outputs(); chk_read(5'd8); chk_read(5'd10);
    // R3: station page with directed checksum corner
    station_addr = 48'hFFFF_FFFF_FFFF;
    do_write(5'd2, 16'hABC1);
    for (int a = 8; a < 16; a++) chk_read(5'(a));
    station_addr = 48'h0;
    chk_read(5'd14);
    // R4: wrap register write on HW page, odd write ignored
    do_write(5'd2, 16'h0002); do_write(5'd14, 16'h7F06); do_write(5'd9, 16'h5555);
    for (int a = 8; a < 16; a++) chk_read(5'(a));
    // R11: unimplemented page ignores writes
    do_write(5'd2, 16'h0003); do_write(5'd14, 16'h1111); chk_read(5'd14);
    do_write(5'd2, 16'h0002); chk_read(5'd14);
    // R9: fake interrupt with enable
    do_write(5'd4, 16'h000C); nic_irq = 1'b0; chk_outputs();
    do_write(5'd4, 16'h0008); chk_outputs();
    // R10: forwarded write leaves board state untouched
    do_write(5'd20, 16'hFFFF); chk_outputs(); chk_read(5'd2); chk_read(5'd20);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [4:0] a;
      randomize_inputs();
      a = 5'($urandom);
      if ($urandom % 3 == 0) a = {2'b00, 3'($urandom % 3) + 3'd1, 1'b0} & 5'h06;
      do_write(a, 16'($urandom));
      chk_outputs();
      chk_read(5'($urandom));
      chk_read(5'(8 + $urandom % 8));
    end
    report();
  end
endmodule